// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor Core

This block is a small stored-program processor built around one accumulator. Every instruction and data word is 16 bits wide. The upper four bits of an instruction select the operation and the lower twelve bits name a direct word address. The core runs one instruction at a time. Each instruction passes through a fetch sequence, a decode step and a short execute sequence, and each micro-step takes one clock cycle. Inside the core are a 12-bit program counter, a 12-bit memory address register, a 16-bit instruction register, a 16-bit memory buffer register and a 16-bit accumulator. It also has an 8-bit output holding register.

Program and data share one internal synchronous word array. A separate preload port writes words into that array, and a test environment uses it to place a program and its constants before releasing reset. Input uses polling. An input instruction stalls the core until the input-valid pin is high, then takes the byte. An output instruction copies the accumulator's low byte to the output pins and pulses a strobe. A halt instruction freezes the core, which stays frozen until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `halted`, `out_strobe`, `in_ack` and `out_data` read zero. Execution then starts with the word at address 0.
- R2: Instruction encoding: bits 15:12 hold the opcode and bits 11:0 hold the address X. Opcodes: 0 jump-and-store, 1 load, 2 store, 3 add, 4 subtract, 5 input, 6 output, 7 halt, 8 conditional skip, 9 jump, A clear, B indirect add, C indirect jump.
- R3: Load sets AC to M[X]. Store writes AC into M[X]. Add and subtract replace AC with AC+M[X] and AC-M[X], wrapping modulo 2^16 in two's complement.
- R4: Conditional skip looks at bits 11:10. 00 skips when AC is negative, 01 skips when AC is zero, 10 skips when AC is positive, and 11 never skips. A skip steps past exactly one following instruction.
- R5: Jump continues at X. Indirect jump continues at the low 12 bits of M[X].
- R6: Indirect add adds M[M[X][11:0]] to AC.
- R7: Jump-and-store writes the address of the instruction after it into M[X], zero-extended, and continues at X+1. AC is left unchanged.
- R8: Input stalls while `in_valid` is low. When it is high, `in_ack` is high for the one cycle in which the byte is taken, and AC becomes the byte zero-extended to 16 bits. `in_ack` is never high while `in_valid` is low.
- R9: Output places AC[7:0] on `out_data` and raises `out_strobe` for exactly one cycle. `out_data` holds its value between outputs.
- R10: Halt raises `halted`, which then stays high. No further output or state change happens until reset clears it.
- R11: Clear sets AC to zero.
- R12: Opcodes D, E and F act as no-ops and leave AC and the output unchanged.
- R13: A cycle with `ld_en` high writes `ld_data` into the word at `ld_addr`. This port takes priority over the core's own writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Preload write enable |
| ld_addr | input | 12 | Preload word address |
| ld_data | input | 16 | Preload word value |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte present |
| in_ack | output | 1 | Input byte taken this cycle |
| out_data | output | 8 | Last output byte |
| out_strobe | output | 1 | One-cycle pulse when out_data is updated |
| halted | output | 1 | Core has executed halt |

## Verification
The assertions assume that `in_data` is stable in any cycle where `in_valid` is high, since the zero-extension property compares AC with the byte seen on the edge that takes it. They also assume that the preload port is idle once the program is running, so that no instruction or operand changes under the core. The stimulus writes all memory only while reset is held. It raises `in_valid` only at falling edges and keeps the byte steady until the cycle after `in_ack`. It holds the first byte back well past the point where the core reaches the input instruction, which makes the stall visible.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  // Opcode values (upper nibble of an instruction word)
  localparam logic [3:0] OP_JNS   = 4'h0;
  localparam logic [3:0] OP_LOAD  = 4'h1;
  localparam logic [3:0] OP_STORE = 4'h2;
  localparam logic [3:0] OP_ADD   = 4'h3;
  localparam logic [3:0] OP_SUB   = 4'h4;
  localparam logic [3:0] OP_IN    = 4'h5;
  localparam logic [3:0] OP_OUT   = 4'h6;
  localparam logic [3:0] OP_HALT  = 4'h7;
  localparam logic [3:0] OP_SKIP  = 4'h8;
  localparam logic [3:0] OP_JUMP  = 4'h9;
  localparam logic [3:0] OP_CLR   = 4'hA;
  localparam logic [3:0] OP_ADDI  = 4'hB;
  localparam logic [3:0] OP_JUMPI = 4'hC;

  typedef enum logic [1:0] {
    ALU_PASS = 2'd0,
    ALU_ADD  = 2'd1,
    ALU_SUB  = 2'd2,
    ALU_ZERO = 2'd3
  } alu_op_e;

  typedef enum logic [3:0] {
    ST_F0   = 4'd0,
    ST_F1   = 4'd1,
    ST_DEC  = 4'd2,
    ST_RD   = 4'd3,
    ST_EX   = 4'd4,
    ST_RD2  = 4'd5,
    ST_EX2  = 4'd6,
    ST_ST   = 4'd7,
    ST_JW   = 4'd8,
    ST_IN   = 4'd9,
    ST_HALT = 4'd10
  } state_e;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  // preload port wins over the core write (R13)
  always_ff @(posedge clk) begin
    if (ld_en)   words[ld_addr] <= ld_data;
    else if (we) words[waddr]   <= wdata;
    rdata <= words[raddr];
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu import acc_cpu_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  alu_op_e           f,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  function automatic logic [DATA_W-1:0] alu_eval(alu_op_e op,
                                                 logic [DATA_W-1:0] x,
                                                 logic [DATA_W-1:0] z);
    case (op)
      ALU_ADD:  return x + z;
      ALU_SUB:  return x - z;
      ALU_ZERO: return '0;
      default:  return z;
    endcase
  endfunction

  assign y = alu_eval(f, a, b);

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl import acc_cpu_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int IO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output alu_op_e           alu_f,
  output logic [DATA_W-1:0] alu_a,
  output logic [DATA_W-1:0] alu_b,
  input  logic [DATA_W-1:0] alu_y,
  input  logic [IO_W-1:0]   in_data,
  input  logic              in_valid,
  output logic              in_ack,
  output logic [IO_W-1:0]   out_data,
  output logic              out_strobe,
  output logic              halted
);
  localparam int OPC_W = DATA_W - ADDR_W;

  state_e            st_q, st_n;
  logic [ADDR_W-1:0] pc_q, pc_n;
  logic [ADDR_W-1:0] mar_q, mar_n;
  logic [DATA_W-1:0] ir_q, ir_n;
  logic [DATA_W-1:0] mbr_q, mbr_n;
  logic [DATA_W-1:0] ac_q, ac_n;
  logic [IO_W-1:0]   out_q, out_n;
  logic              strobe_q, strobe_n;

  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] adr;
  logic [1:0]        cond;
  logic              skip_now;
  logic              take_input;

  // skip test on AC, condition code from IR bits just under the opcode
  function automatic logic skip_hit(logic [1:0] c, logic [DATA_W-1:0] v);
    case (c)
      2'b00:   return v[DATA_W-1];
      2'b01:   return v == '0;
      2'b10:   return !v[DATA_W-1] && (v != '0);
      default: return 1'b0;
    endcase
  endfunction

  assign opc        = ir_q[DATA_W-1:ADDR_W];
  assign adr        = ir_q[ADDR_W-1:0];
  assign cond       = ir_q[ADDR_W-1:ADDR_W-2];
  assign skip_now   = (st_q == ST_DEC) && (opc == OPC_W'(OP_SKIP)) && skip_hit(cond, ac_q);
  assign take_input = (st_q == ST_IN) && in_valid;

  assign alu_a = ac_q;
  assign alu_b = mbr_q;

  always_comb begin
    alu_f = ALU_PASS;
    case (st_q)
      ST_DEC: if (opc == OPC_W'(OP_CLR)) alu_f = ALU_ZERO;
      ST_EX: begin
        if (opc == OPC_W'(OP_ADD))      alu_f = ALU_ADD;
        else if (opc == OPC_W'(OP_SUB)) alu_f = ALU_SUB;
      end
      ST_EX2:  alu_f = ALU_ADD;
      default: alu_f = ALU_PASS;
    endcase
  end

  always_comb begin
    st_n     = st_q;
    pc_n     = pc_q;
    mar_n    = mar_q;
    ir_n     = ir_q;
    mbr_n    = mbr_q;
    ac_n     = ac_q;
    out_n    = out_q;
    strobe_n = 1'b0;
    mem_we   = 1'b0;
    case (st_q)
      ST_F0: begin
        mar_n = pc_q;
        st_n  = ST_F1;
      end
      ST_F1: begin
        ir_n = rdata;
        pc_n = pc_q + 1'b1;
        st_n = ST_DEC;
      end
      ST_DEC: begin
        st_n = ST_F0;
        case (opc)
          OPC_W'(OP_LOAD), OPC_W'(OP_ADD), OPC_W'(OP_SUB),
          OPC_W'(OP_ADDI), OPC_W'(OP_JUMPI): begin
            mar_n = adr;
            st_n  = ST_RD;
          end
          OPC_W'(OP_STORE): begin
            mar_n = adr;
            mbr_n = ac_q;
            st_n  = ST_ST;
          end
          OPC_W'(OP_JNS): begin
            mar_n = adr;
            mbr_n = DATA_W'(pc_q);
            st_n  = ST_JW;
          end
          OPC_W'(OP_IN):   st_n = ST_IN;
          OPC_W'(OP_OUT): begin
            out_n    = ac_q[IO_W-1:0];
            strobe_n = 1'b1;
          end
          OPC_W'(OP_HALT): st_n = ST_HALT;
          OPC_W'(OP_SKIP): if (skip_now) pc_n = pc_q + 1'b1;
          OPC_W'(OP_JUMP): pc_n = adr;
          OPC_W'(OP_CLR):  ac_n = alu_y;
          default: ;
        endcase
      end
      ST_RD: begin
        mbr_n = rdata;
        st_n  = ST_EX;
      end
      ST_EX: begin
        st_n = ST_F0;
        case (opc)
          OPC_W'(OP_LOAD), OPC_W'(OP_ADD), OPC_W'(OP_SUB): ac_n = alu_y;
          OPC_W'(OP_ADDI): begin
            mar_n = mbr_q[ADDR_W-1:0];
            st_n  = ST_RD2;
          end
          OPC_W'(OP_JUMPI): pc_n = mbr_q[ADDR_W-1:0];
          default: ;
        endcase
      end
      ST_RD2: begin
        mbr_n = rdata;
        st_n  = ST_EX2;
      end
      ST_EX2: begin
        ac_n = alu_y;
        st_n = ST_F0;
      end
      ST_ST: begin
        mem_we = 1'b1;
        st_n   = ST_F0;
      end
      ST_JW: begin
        mem_we = 1'b1;
        pc_n   = mar_q + 1'b1;
        st_n   = ST_F0;
      end
      ST_IN: begin
        if (take_input) begin
          ac_n = DATA_W'(in_data);
          st_n = ST_F0;
        end
      end
      ST_HALT: ;
      default: st_n = ST_F0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_F0;
      pc_q     <= '0;
      mar_q    <= '0;
      ir_q     <= '0;
      mbr_q    <= '0;
      ac_q     <= '0;
      out_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      st_q     <= st_n;
      pc_q     <= pc_n;
      mar_q    <= mar_n;
      ir_q     <= ir_n;
      mbr_q    <= mbr_n;
      ac_q     <= ac_n;
      out_q    <= out_n;
      strobe_q <= strobe_n;
    end
  end

  // read address follows the MAR value being loaded, so data lines up with MAR
  assign mem_raddr  = mar_n;
  assign mem_waddr  = mar_q;
  assign mem_wdata  = mbr_q;
  assign in_ack     = take_input;
  assign out_data   = out_q;
  assign out_strobe = strobe_q;
  assign halted     = (st_q == ST_HALT);

  // R10: once halted, stays halted
  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R10: no architectural change while halted
  p_halt_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(pc_q) && $stable(ac_q) && !out_strobe));

  // R9: strobe is a single-cycle pulse
  p_strobe_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |=> !out_strobe);

  // R8: the byte taken lands zero-extended in AC
  p_input_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take_input |=> (ac_q == DATA_W'($past(in_data))));

  // R4: zero test with AC zero advances PC by one
  p_skip_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEC && opc == OPC_W'(OP_SKIP) && cond == 2'b01 && ac_q == '0)
      |=> (pc_q == $past(pc_q) + 1'b1));

  // R4: condition code 11 never moves PC
  p_skip_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DEC && opc == OPC_W'(OP_SKIP) && cond == 2'b11) |=> $stable(pc_q));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core import acc_cpu_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int IO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [IO_W-1:0]   in_data,
  input  logic              in_valid,
  output logic              in_ack,
  output logic [IO_W-1:0]   out_data,
  output logic              out_strobe,
  output logic              halted
);
  logic [ADDR_W-1:0] mem_raddr;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic              mem_we;
  alu_op_e           alu_f;
  logic [DATA_W-1:0] alu_a;
  logic [DATA_W-1:0] alu_b;
  logic [DATA_W-1:0] alu_y;

  acc_cpu_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .ld_en   (ld_en),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr   (mem_raddr),
    .rdata   (mem_rdata)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .f (alu_f),
    .a (alu_a),
    .b (alu_b),
    .y (alu_y)
  );

  acc_cpu_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IO_W(IO_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdata      (mem_rdata),
    .mem_raddr  (mem_raddr),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .alu_f      (alu_f),
    .alu_a      (alu_a),
    .alu_b      (alu_b),
    .alu_y      (alu_y),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_ack     (in_ack),
    .out_data   (out_data),
    .out_strobe (out_strobe),
    .halted     (halted)
  );

endmodule

// File: tb/acc_cpu_core_tb.sv
`timescale 1ns/1ps
module acc_cpu_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_en = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ack;
  logic [7:0]  out_data;
  logic        out_strobe;
  logic        halted;

  int checks = 0;
  int fails = 0;
  int seen = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  acc_cpu_core u_dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .in_data(in_data), .in_valid(in_valid), .in_ack(in_ack),
    .out_data(out_data), .out_strobe(out_strobe), .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ld(input logic [11:0] a, input logic [15:0] d);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en && out_strobe) begin
      seen++;
      if (exp_q.size() == 0) chk(1'b0, "R9/R10 unexpected output", out_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(out_data == e, "R9 output value", out_data, e);
      end
    end
    if (mon_en && in_ack && !in_valid) chk(1'b0, "R8 ack without valid", 1, 0);
  end

  task automatic give_input(input logic [7:0] b);
    in_data = b; in_valid = 1'b1;
    #1;
    while (!in_ack) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    logic [15:0] a5, s1, ai;
    @(negedge clk);
    // R13: program and data through the preload port (R2 encodings)
    ld(12'h000, 16'h1040); ld(12'h001, 16'h3041); ld(12'h002, 16'h6000);
    ld(12'h003, 16'h4042); ld(12'h004, 16'h6000); ld(12'h005, 16'h8000);
    ld(12'h006, 16'h7000); ld(12'h007, 16'h2043); ld(12'h008, 16'hA000);
    ld(12'h009, 16'h6000); ld(12'h00A, 16'h8400); ld(12'h00B, 16'h7000);
    ld(12'h00C, 16'h1043); ld(12'h00D, 16'h6000); ld(12'h00E, 16'h8400);
    ld(12'h00F, 16'h9020); ld(12'h010, 16'h7000);
    ld(12'h020, 16'h8800); ld(12'h021, 16'h1040); ld(12'h022, 16'h8800);
    ld(12'h023, 16'h7000); ld(12'h024, 16'h8C00); ld(12'h025, 16'h6000);
    ld(12'h026, 16'hB044); ld(12'h027, 16'h6000); ld(12'h028, 16'hD000);
    ld(12'h029, 16'hF123); ld(12'h02A, 16'h6000); ld(12'h02B, 16'hE000);
    ld(12'h02C, 16'h5000); ld(12'h02D, 16'h6000); ld(12'h02E, 16'hC045);
    ld(12'h02F, 16'h7000);
    ld(12'h030, 16'h0060); ld(12'h031, 16'h6000); ld(12'h032, 16'h1047);
    ld(12'h033, 16'h5000); ld(12'h034, 16'h8800); ld(12'h035, 16'h7000);
    ld(12'h036, 16'h6000); ld(12'h037, 16'h7000);
    ld(12'h040, 16'h0005); ld(12'h041, 16'h0007); ld(12'h042, 16'h0014);
    ld(12'h043, 16'h0000); ld(12'h044, 16'h0050); ld(12'h045, 16'h0030);
    ld(12'h047, 16'hFF00); ld(12'h050, 16'h0021);
    ld(12'h060, 16'h0000); ld(12'h061, 16'h1060); ld(12'h062, 16'h6000);
    ld(12'h063, 16'hC060);

    // expected output stream
    s1 = 16'd5 + 16'd7;
    exp_q.push_back(s1[7:0]);                 // R3 add
    a5 = s1 - 16'd20;
    exp_q.push_back(a5[7:0]);                 // R3 subtract wraps
    exp_q.push_back(8'h00);                   // R11 clear
    exp_q.push_back(a5[7:0]);                 // R3 store then load
    exp_q.push_back(8'h05);                   // R4 code 11 no skip
    ai = 16'd5 + 16'h0021;
    exp_q.push_back(ai[7:0]);                 // R6 indirect add
    exp_q.push_back(ai[7:0]);                 // R12 no-ops
    exp_q.push_back(8'hA5);                   // R8 input
    exp_q.push_back(8'h31);                   // R7 stored return address
    exp_q.push_back(8'h31);                   // R7/R5 return via indirect jump
    exp_q.push_back(8'h5A);                   // R8 zero-extension via skip

    // R1 reset state
    chk(halted == 1'b0 && out_strobe == 1'b0, "R1 reset flags", {halted, out_strobe}, 0);
    chk(out_data == 8'h00 && in_ack == 1'b0, "R1 reset data", out_data, 0);
    mon_en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(halted == 1'b0 && out_strobe == 1'b0, "R1 after release", {halted, out_strobe}, 0);

    // R8: core must stall at the input instruction
    repeat (400) @(negedge clk);
    chk(seen == 7, "R8 stall before valid", seen, 7);
    chk(halted == 1'b0, "R8 not halted while waiting", halted, 0);
    give_input(8'hA5);
    repeat (20) @(negedge clk);
    give_input(8'h5A);

    // R10 halt
    begin
      int n = 0;
      while (!halted && n < 500) begin @(negedge clk); n++; end
    end
    chk(halted == 1'b1, "R10 halted", halted, 1);
    chk(seen == 11, "R9 output count (R4 R5 R7 skips)", seen, 11);
    chk(exp_q.size() == 0, "R9 all expected outputs", exp_q.size(), 0);
    repeat (50) @(negedge clk);
    chk(halted == 1'b1, "R10 halted stays", halted, 1);
    chk(seen == 11, "R10 no output while halted", seen, 11);
    chk(out_data == 8'h5A, "R9 out_data holds", out_data, 8'h5A);

    // R10: reset clears halt
    mon_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk(halted == 1'b0, "R10 reset clears halt", halted, 0);
    chk(out_data == 8'h00, "R1 reset clears output", out_data, 0);
    done = 1'b1;
    finish_run();
  end

endmodule